// File: doc/BRIEF.md
# Two-Phase Bank Occupancy Guard for Tag and Data Arrays

This block tracks which banks of a multi-bank storage array are occupied by an access that lasts several cycles. It is meant for a cache controller in which one operation may need both a tag-array bank and a data-array bank. Two tracker instances sit inside the block, one for the tag array and one for the data array. Each instance answers a combinational availability query per lane without changing any state. A bank becomes busy only when a separate reserve is applied.

A grant stage joins the two trackers. A requester lane names the set index it needs in each array and which of the two arrays it needs. The lane is granted only when every needed bank is available, and only then are those banks reserved. Because of this, a lane never holds one resource while it waits for the other, and two lanes that ask for the same pair of resources cannot each end up holding half of it.

Lane 0 has priority within a cycle. Lane 1 sees lane 0's reservations of the same cycle. A force input reserves a lane's needed banks without the grant check. A force onto an occupied bank is illegal and raises a sticky error. When resource stalls are disabled, every request is granted and nothing is reserved.

Top module: `bank_pair_guard`

## Requirements
- R1: After reset, every bank of both arrays is free (all `*_ok_o` bits are 1 with no reservation pending) and `err_o` is 0.
- R2: The availability outputs are pure queries. Presenting an index, without a grant or force, never makes that bank busy in a later cycle.
- R3: A reservation made in cycle c on an array of latency L (L >= 1) makes that bank report unavailable in cycles c+1 through c+L-1. The bank reports available again from cycle c+L. Defaults are L=2 for tags and L=3 for data.
- R4: The bank is chosen by index bits [1:0] (4 banks by default). Reservations in different banks do not affect each other.
- R5: In the same cycle, lane 1 sees a bank as unavailable if lane 0 reserves that bank with a different index. If lane 0 reserves the same index, lane 1 still sees the bank as available, and both reservations are accepted as one.
- R6: With stalls enabled, a lane is granted only if it requests and every array it needs (need_tag bit, need_data bit) reports available. A granted lane reserves all of its needed banks, and a lane that is not granted reserves none of them.
- R7: Lane 0 is evaluated first. When both lanes contend for the same bank with different indices, lane 0 wins.
- R8: With `stall_en_i` = 0, `gnt_o` equals `req_i`, and no bank is reserved by a grant or a force.
- R9: A force (`force_i[k]` = 1, with stalls enabled) onto a bank that is unavailable to that lane leaves the bank unchanged. It sets `err_o` from the next cycle, and `err_o` stays set until reset.
- R10: With a latency parameter of 0, that array reports every bank available at all times and never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_en_i | input | 1 | Enables resource tracking |
| req_i | input | 2 | Per-lane request |
| force_i | input | 2 | Per-lane unchecked reservation |
| need_tag_i | input | 2 | Lane needs a tag-array bank |
| need_data_i | input | 2 | Lane needs a data-array bank |
| tag_idx_i | input | 2x8 | Per-lane tag set index |
| data_idx_i | input | 2x8 | Per-lane data set index |
| gnt_o | output | 2 | Per-lane all-or-nothing grant |
| tag_ok_o | output | 2 | Per-lane tag bank availability |
| data_ok_o | output | 2 | Per-lane data bank availability |
| err_o | output | 1 | Sticky illegal-reservation flag |

## Verification
A bank whose end cycle is recorded wrong shows up on the availability outputs in the cycle right after the reservation, or one cycle too late when the window is released. The stimulus therefore probes every cycle across each busy window. A reservation that leaks from a denied lane makes a bank busy that should be free, and this is seen one cycle later when another lane is refused. A missed same-cycle conflict between lanes shows at once as a double grant. An error flag that is not sticky, or that fires for the wrong cause, shows on `err_o` one cycle after a legal or an illegal force.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;
  localparam int LANES = 2;
  typedef enum logic {RES_TAG = 1'b0, RES_DATA = 1'b1} res_e;
endpackage

// File: rtl/cycle_ctr.sv
module cycle_ctr #(
  parameter int CYC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CYC_W-1:0] cyc_o
);
  logic [CYC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cyc_o = cnt_q;
endmodule

// File: rtl/bank_slot.sv
module bank_slot #(
  parameter int unsigned CYC_W = 32,
  parameter int unsigned LAT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             set_i,
  output logic             busy_o
);
  logic             valid_q;
  logic [CYC_W-1:0] end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      end_q   <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      end_q   <= cyc_i + CYC_W'(LAT - 1);
    end
  end

  // busy while the recorded last cycle has not yet passed
  assign busy_o = valid_q && (end_q >= cyc_i);
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned LAT       = 2,
  parameter int unsigned CYC_W     = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CYC_W-1:0]            cyc_i,
  input  logic [LANES-1:0][IDX_W-1:0] idx_i,
  input  logic [LANES-1:0]            rsv_i,
  output logic [LANES-1:0]            ok_o,
  output logic                        err_o
);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  if (LAT == 0) begin : g_untracked
    logic unused_in;
    assign unused_in = ^{cyc_i, idx_i, rsv_i, clk_i, rst_ni};
    assign ok_o  = '1;
    assign err_o = 1'b0;
  end else begin : g_tracked
    logic [NUM_BANKS-1:0]         busy;
    logic [NUM_BANKS-1:0]         set;
    logic [LANES-1:0][BANK_W-1:0] bsel;
    logic [LANES-1:0]             ok;
    logic [LANES-1:0]             bad;
    logic                         err_q;

    always_comb begin
      set = '0;
      ok  = '0;
      bad = '0;
      for (int k = 0; k < LANES; k++) begin
        bsel[k] = idx_i[k][BANK_W-1:0];
        ok[k]   = !busy[bsel[k]];
        // earlier lanes reserving this cycle count as occupying the bank
        for (int j = 0; j < k; j++) begin
          if (rsv_i[j] && (bsel[j] == bsel[k]) && (idx_i[j] != idx_i[k])) ok[k] = 1'b0;
        end
        bad[k] = rsv_i[k] && !ok[k];
        if (rsv_i[k] && ok[k]) set[bsel[k]] = 1'b1;
      end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bank_slot #(.CYC_W(CYC_W), .LAT(LAT)) u_slot (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .cyc_i (cyc_i),
        .set_i (set[b]),
        .busy_o(busy[b])
      );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  err_q <= 1'b0;
      else if (|bad) err_q <= 1'b1;
    end

    assign ok_o  = ok;
    assign err_o = err_q;
  end
endmodule

// File: rtl/bank_pair_guard.sv
module bank_pair_guard
  import bank_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned TAG_LAT   = 2,
  parameter int unsigned DATA_LAT  = 3,
  parameter int unsigned CYC_W     = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        stall_en_i,
  input  logic [LANES-1:0]            req_i,
  input  logic [LANES-1:0]            force_i,
  input  logic [LANES-1:0]            need_tag_i,
  input  logic [LANES-1:0]            need_data_i,
  input  logic [LANES-1:0][IDX_W-1:0] tag_idx_i,
  input  logic [LANES-1:0][IDX_W-1:0] data_idx_i,
  output logic [LANES-1:0]            gnt_o,
  output logic [LANES-1:0]            tag_ok_o,
  output logic [LANES-1:0]            data_ok_o,
  output logic                        err_o
);
  localparam int unsigned NRES = 2;

  logic [CYC_W-1:0]            cyc;
  logic [NRES-1:0][LANES-1:0]  rsv;
  logic [NRES-1:0][LANES-1:0]  ok;
  logic [NRES-1:0][LANES-1:0]  need;
  logic [NRES-1:0]             err;
  logic [LANES-1:0]            gnt;

  cycle_ctr #(.CYC_W(CYC_W)) u_cyc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cyc_o (cyc)
  );

  assign need[RES_TAG]  = need_tag_i;
  assign need[RES_DATA] = need_data_i;

  for (genvar r = 0; r < NRES; r++) begin : g_res
    localparam int unsigned R_LAT = (r == int'(RES_TAG)) ? TAG_LAT : DATA_LAT;
    logic [LANES-1:0][IDX_W-1:0] idx;
    assign idx = (r == int'(RES_TAG)) ? tag_idx_i : data_idx_i;

    bank_tracker #(
      .NUM_BANKS(NUM_BANKS),
      .IDX_W    (IDX_W),
      .LAT      (R_LAT),
      .CYC_W    (CYC_W)
    ) u_trk (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cyc_i (cyc),
      .idx_i (idx),
      .rsv_i (rsv[r]),
      .ok_o  (ok[r]),
      .err_o (err[r])
    );
  end

  // all-or-nothing grant; reservation only after every check of the lane passed
  always_comb begin
    gnt = '0;
    rsv = '0;
    for (int k = 0; k < LANES; k++) begin
      logic all_ok;
      all_ok = 1'b1;
      for (int r = 0; r < NRES; r++) begin
        if (need[r][k] && !ok[r][k]) all_ok = 1'b0;
      end
      gnt[k] = req_i[k] && (!stall_en_i || all_ok);
      for (int r = 0; r < NRES; r++) begin
        rsv[r][k] = stall_en_i && need[r][k] && (gnt[k] || force_i[k]);
      end
    end
  end

  assign gnt_o     = gnt;
  assign tag_ok_o  = ok[RES_TAG];
  assign data_ok_o = ok[RES_DATA];
  assign err_o     = |err;
endmodule

// File: rtl/bank_pair_guard_chk.sv
module bank_pair_guard_chk
  import bank_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned TAG_LAT   = 2,
  parameter int unsigned DATA_LAT  = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        stall_en_i,
  input logic [LANES-1:0]            req_i,
  input logic [LANES-1:0]            force_i,
  input logic [LANES-1:0]            need_tag_i,
  input logic [LANES-1:0]            need_data_i,
  input logic [LANES-1:0][IDX_W-1:0] tag_idx_i,
  input logic [LANES-1:0][IDX_W-1:0] data_idx_i,
  input logic [LANES-1:0]            gnt_o,
  input logic [LANES-1:0]            tag_ok_o,
  input logic [LANES-1:0]            data_ok_o,
  input logic                        err_o
);
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  logic unused_chk;
  assign unused_chk = ^{data_idx_i, DATA_LAT[0]};

  p_gnt_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  p_gnt_lane0_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_en_i && gnt_o[0]) |-> ((!need_tag_i[0] || tag_ok_o[0]) && (!need_data_i[0] || data_ok_o[0])));

  p_gnt_lane1_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_en_i && gnt_o[1]) |-> ((!need_tag_i[1] || tag_ok_o[1]) && (!need_data_i[1] || data_ok_o[1])));

  p_nostall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_en_i |-> (gnt_o == req_i));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $rose(err_o)) |-> $past(stall_en_i && (|force_i)));

  p_lane_clash_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_en_i && gnt_o[0] && need_tag_i[0] && (TAG_LAT != 0) &&
     (tag_idx_i[0][BW-1:0] == tag_idx_i[1][BW-1:0]) && (tag_idx_i[0] != tag_idx_i[1]))
    |-> !tag_ok_o[1]);

  if (TAG_LAT >= 2) begin : g_hold
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $past(stall_en_i && gnt_o[0] && need_tag_i[0]) &&
       ($past(tag_idx_i[0][BW-1:0]) == tag_idx_i[0][BW-1:0])) |-> !tag_ok_o[0]);
  end

  if (TAG_LAT == 0) begin : g_zero
    p_zero_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tag_ok_o == '1));
  end
endmodule

bind bank_pair_guard bank_pair_guard_chk #(
  .NUM_BANKS(NUM_BANKS),
  .IDX_W    (IDX_W),
  .TAG_LAT  (TAG_LAT),
  .DATA_LAT (DATA_LAT)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_en_i (stall_en_i),
  .req_i      (req_i),
  .force_i    (force_i),
  .need_tag_i (need_tag_i),
  .need_data_i(need_data_i),
  .tag_idx_i  (tag_idx_i),
  .data_idx_i (data_idx_i),
  .gnt_o      (gnt_o),
  .tag_ok_o   (tag_ok_o),
  .data_ok_o  (data_ok_o),
  .err_o      (err_o)
);

// File: tb/bank_pair_guard_tb_top.sv
module bank_pair_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_en;
  logic [1:0] req, frc, ntag, ndat;
  logic [1:0][7:0] tidx, didx;
  logic [1:0] gnt, tok, dok, gnt_z, tok_z, dok_z;
  logic err, err_z;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bank_pair_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stall_en_i(stall_en), .req_i(req), .force_i(frc),
    .need_tag_i(ntag), .need_data_i(ndat), .tag_idx_i(tidx), .data_idx_i(didx),
    .gnt_o(gnt), .tag_ok_o(tok), .data_ok_o(dok), .err_o(err));

  bank_pair_guard #(.TAG_LAT(0), .DATA_LAT(0)) dut_z_i (
    .clk_i(clk), .rst_ni(rst_n), .stall_en_i(stall_en), .req_i(req), .force_i(frc),
    .need_tag_i(ntag), .need_data_i(ndat), .tag_idx_i(tidx), .data_idx_i(didx),
    .gnt_o(gnt_z), .tag_ok_o(tok_z), .data_ok_o(dok_z), .err_o(err_z));

  typedef struct packed {
    logic       stall;
    logic [1:0] rq, fc, nt, nd;
    logic [7:0] t0, d0, t1, d1;
    logic [1:0] e_gnt, e_tok, e_dok;
    logic       e_err;
  } vec_t;

  // tag latency 2, data latency 3, bank = idx[1:0]
  localparam vec_t VECS [15] = '{
    '{1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0,  8'd0,  8'd0,  8'd0,  2'b00, 2'b11, 2'b11, 1'b0}, // R1 idle
    '{1'b1, 2'b01, 2'b00, 2'b01, 2'b01, 8'd4,  8'd9,  8'd0,  8'd0,  2'b01, 2'b01, 2'b11, 1'b0}, // R5 lane1 clash
    '{1'b1, 2'b10, 2'b00, 2'b10, 2'b10, 8'd4,  8'd9,  8'd8,  8'd13, 2'b00, 2'b00, 2'b00, 1'b0}, // R3 busy
    '{1'b1, 2'b10, 2'b00, 2'b10, 2'b10, 8'd4,  8'd9,  8'd8,  8'd13, 2'b00, 2'b11, 2'b00, 1'b0}, // R6 partial denied
    '{1'b1, 2'b10, 2'b00, 2'b10, 2'b10, 8'd4,  8'd9,  8'd8,  8'd13, 2'b10, 2'b11, 2'b11, 1'b0}, // R2 check left free
    '{1'b1, 2'b11, 2'b00, 2'b11, 2'b11, 8'd2,  8'd3,  8'd6,  8'd7,  2'b01, 2'b01, 2'b01, 1'b0}, // R7 lane0 wins
    '{1'b1, 2'b11, 2'b00, 2'b11, 2'b11, 8'd2,  8'd3,  8'd6,  8'd7,  2'b00, 2'b00, 2'b00, 1'b0}, // R3
    '{1'b1, 2'b11, 2'b00, 2'b11, 2'b11, 8'd2,  8'd3,  8'd6,  8'd7,  2'b00, 2'b11, 2'b00, 1'b0}, // R6 no half hold
    '{1'b1, 2'b10, 2'b00, 2'b11, 2'b11, 8'd2,  8'd3,  8'd6,  8'd7,  2'b10, 2'b11, 2'b11, 1'b0}, // R4 other banks
    '{1'b1, 2'b11, 2'b00, 2'b11, 2'b11, 8'd17, 8'd20, 8'd17, 8'd20, 2'b11, 2'b11, 2'b11, 1'b0}, // R5 same index
    '{1'b0, 2'b11, 2'b00, 2'b11, 2'b11, 8'd17, 8'd20, 8'd17, 8'd20, 2'b11, 2'b00, 2'b00, 1'b0}, // R8 stall off
    '{1'b1, 2'b00, 2'b01, 2'b01, 2'b00, 8'd17, 8'd20, 8'd17, 8'd20, 2'b00, 2'b11, 2'b00, 1'b0}, // R9 legal force
    '{1'b1, 2'b00, 2'b01, 2'b01, 2'b00, 8'd17, 8'd20, 8'd17, 8'd20, 2'b00, 2'b00, 2'b11, 1'b0}, // R9 illegal force
    '{1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 8'd17, 8'd20, 8'd17, 8'd20, 2'b00, 2'b11, 2'b11, 1'b1}, // R9 flag, bank untouched
    '{1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 8'd17, 8'd20, 8'd17, 8'd20, 2'b00, 2'b11, 2'b11, 1'b1}  // R9 sticky
  };

  task automatic chk(input bit ok, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    stall_en = 1'b1; req = '0; frc = '0; ntag = '0; ndat = '0; tidx = '0; didx = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      finish_run();
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    #3;
    chk(err == 1'b0, "R1 err in reset", {7'd0, err}, 8'd0);
    chk(tok == 2'b11 && dok == 2'b11, "R1 free in reset", {4'd0, tok, dok}, 8'h0f);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      stall_en = VECS[i].stall; req = VECS[i].rq; frc = VECS[i].fc;
      ntag = VECS[i].nt; ndat = VECS[i].nd;
      tidx[0] = VECS[i].t0; tidx[1] = VECS[i].t1;
      didx[0] = VECS[i].d0; didx[1] = VECS[i].d1;
      #3;
      chk(gnt == VECS[i].e_gnt, $sformatf("R6 gnt row %0d", i), {6'd0, gnt}, {6'd0, VECS[i].e_gnt});
      chk(tok == VECS[i].e_tok, $sformatf("R3 tag_ok row %0d", i), {6'd0, tok}, {6'd0, VECS[i].e_tok});
      chk(dok == VECS[i].e_dok, $sformatf("R3 data_ok row %0d", i), {6'd0, dok}, {6'd0, VECS[i].e_dok});
      chk(err == VECS[i].e_err, $sformatf("R9 err row %0d", i), {7'd0, err}, {7'd0, VECS[i].e_err});
      chk(tok_z == 2'b11 && dok_z == 2'b11, $sformatf("R10 zero-lat ok row %0d", i),
          {4'd0, tok_z, dok_z}, 8'h0f);
      chk(gnt_z == req, $sformatf("R10 zero-lat gnt row %0d", i), {6'd0, gnt_z}, {6'd0, req});
    end

    // R10: clashing forces on a zero-latency array raise nothing
    @(negedge clk);
    idle(); frc = 2'b11; ntag = 2'b11; ndat = 2'b11;
    tidx[0] = 8'd1; tidx[1] = 8'd5; didx[0] = 8'd2; didx[1] = 8'd6;
    @(negedge clk);
    frc = 2'b11;
    @(negedge clk);
    idle();
    #3;
    chk(err_z == 1'b0, "R10 zero-lat err", {7'd0, err_z}, 8'd0);

    // R1: reset clears the sticky flag and all busy banks
    @(negedge clk);
    req = 2'b01; ntag = 2'b01; ndat = 2'b01; tidx[0] = 8'd3; didx[0] = 8'd3;
    @(negedge clk);
    idle(); tidx[0] = 8'd3; didx[0] = 8'd3;
    rst_n = 1'b0;
    #3;
    chk(err == 1'b0, "R1 err cleared", {7'd0, err}, 8'd0);
    chk(tok[0] && dok[0], "R1 bank freed", {6'd0, tok[0], dok[0]}, 8'd3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk(err == 1'b0, "R1 err after release", {7'd0, err}, 8'd0);

    finish_run();
  end
endmodule